// File: doc/BRIEF.md
# Parallel Port Mode Negotiation Sequencer

This block is the host side of the mode negotiation handshake on a parallel printer port. A controller puts the requested extensibility byte on `req_byte_i` and pulses `start_i`. The sequencer then drives the byte onto the data lines and raises SelectIn# while pulling AutoFeed# low. It waits for the peripheral to answer, strobes the byte into the peripheral, and releases Strobe# and AutoFeed#. When the peripheral raises Ack#, the sequencer samples the peripheral's status reply.

At the end it gives a one-cycle `done_o` pulse with one of four outcome codes. It also reports whether the peripheral has reverse-channel data waiting. The four peripheral inputs are asynchronous, and each passes through a two-flop synchronizer. Each wait for the peripheral is bounded by a timeout counted in clocks. The sequencer does not enter the agreed mode and does not move any data. After `done_o`, the port lines return to their compatibility-mode idle levels, and a downstream block takes over.

The state machine has six states: IDLE, SETUP, REQ, STROBE, RELEASE and FINISH. Its transitions are:
- IDLE→SETUP on `start_i`, which also latches the byte.
- SETUP→REQ unconditionally after one clock.
- REQ→STROBE when a valid reply is seen, or REQ→FINISH when the first wait times out.
- STROBE→RELEASE after the pulse width.
- RELEASE→FINISH when Ack# goes high, or when the second wait times out.
- FINISH→IDLE unconditionally.

Top module: `nego_seq`

## Requirements
- R1: After reset, and again once a sequence ends, the outputs sit at idle levels: `data_o`=0x00, `sel_in_n_o`=0, `auto_fd_n_o`=1, `strobe_n_o`=1, `busy_o`=0, `done_o`=0.
- R2: A `start_i` seen in IDLE latches `req_byte_i`. In the next cycle `data_o` shows the byte while the control lines are still idle. In the cycle after that, `sel_in_n_o`=1 and `auto_fd_n_o`=0.
- R3: The sequencer accepts a reply only when the synchronized inputs show Ack# low together with Error# high, PaperEnd high and Select high. Any other combination is not a reply. If no valid reply arrives, the outcome is `result_o`=2'b00 (non-compliant).
- R4: With no reply, SelectIn# stays high for exactly TIMEOUT_CLKS clocks. A reply driven d cycles after SelectIn# first rises is accepted only when d+3 ≤ TIMEOUT_CLKS; the three cycles cover the two synchronizer flops.
- R5: Strobe# is low for exactly max(STB_CLKS,1) clocks. During the pulse, SelectIn# stays high, AutoFeed# stays low and `data_o` holds the latched byte.
- R6: In the cycle after the pulse ends, Strobe# and AutoFeed# are both high and SelectIn# is still high. The sequencer then waits for Ack# to go high.
- R7: When Ack# rises, the outcome is `result_o`=2'b01 (accepted) if Select is high, and 2'b10 (rejected) if Select is low. A request byte equal to NIBBLE_CODE (0x00) is always reported as accepted.
- R8: `rev_avail_o` is set only when PaperEnd and Error# are both low as Ack# rises. It is 0 for every other outcome.
- R9: If Ack# does not rise within TIMEOUT_CLKS clocks after the pulse, the outcome is `result_o`=2'b11 (failed) with `rev_avail_o`=0.
- R10: `done_o` is high for exactly one cycle per sequence. `result_o` and `rev_avail_o` hold their values until the next `done_o`.
- R11: A `start_i` pulse while `busy_o` is high has no effect: the latched byte, the outcome and the sequence length are unchanged, and no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only in IDLE |
| req_byte_i | input | 8 | Requested extensibility byte |
| ack_n_i | input | 1 | Peripheral Ack# line (asynchronous) |
| err_n_i | input | 1 | Peripheral Error# line (asynchronous) |
| pe_i | input | 1 | Peripheral PaperEnd line (asynchronous) |
| slct_i | input | 1 | Peripheral Select line (asynchronous) |
| data_o | output | 8 | Port data lines |
| sel_in_n_o | output | 1 | SelectIn# line |
| auto_fd_n_o | output | 1 | AutoFeed# line |
| strobe_n_o | output | 1 | Strobe# line |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| result_o | output | 2 | Outcome: 00 non-compliant, 01 accepted, 10 rejected, 11 failed |
| rev_avail_o | output | 1 | Peripheral reports reverse data waiting |

## Verification
The bench builds the sequencer with TIMEOUT_CLKS=40 and STB_CLKS=3. This keeps every timeout a few dozen cycles long, so the full decode sweep fits easily in the run. The sweep covers six request bytes (the nibble code among them), both Select levels and all four PaperEnd/Error# combinations, with varied reply delays. The short timeout also puts the exact reply-deadline boundary (delays of 37 and 38 cycles) within reach. The remaining cases are malformed first replies, a silent device, a device that never raises Ack#, and a start pulse issued mid-sequence.

// File: rtl/nego_pkg.sv
package nego_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_REQ,
        ST_STROBE,
        ST_RELEASE,
        ST_FINISH
    } nego_state_e;

    typedef enum logic [1:0] {
        RES_NONCOMPLIANT = 2'b00,
        RES_ACCEPT       = 2'b01,
        RES_REJECT       = 2'b10,
        RES_FAIL         = 2'b11
    } nego_result_e;

endpackage

// File: rtl/nego_sync.sv
module nego_sync #(
    parameter int               WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    // two flops per line, one generate instance per bit
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= async_i[b];
                stab_q <= meta_q;
            end
        end

        assign sync_o[b] = stab_q;
    end

endmodule

// File: rtl/nego_timer.sv
module nego_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    // saturating cycle counter, cleared on every state entry that needs it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (cnt_o != {CNT_W{1'b1}}) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/nego_fsm.sv
module nego_fsm
    import nego_pkg::*;
#(
    parameter int         TIMEOUT_CLKS = 2000,
    parameter int         STB_CLKS     = 4,
    parameter int         CNT_W        = 11,
    parameter logic [7:0] NIBBLE_CODE  = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       req_i,
    input  logic             ack_n_s_i,
    input  logic             err_n_s_i,
    input  logic             pe_s_i,
    input  logic             slct_s_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             cnt_clr_o,
    output logic [7:0]       data_o,
    output logic             sel_in_n_o,
    output logic             auto_fd_n_o,
    output logic             strobe_n_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       result_o,
    output logic             rev_avail_o
);

    localparam int              STB_EFF  = (STB_CLKS < 1) ? 1 : STB_CLKS;
    localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CLKS - 1);
    localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STB_EFF - 1);

    nego_state_e  state_q, state_n;
    logic [7:0]   req_q;
    nego_result_e result_q, res_n;
    logic         rev_q, rev_n, res_we;

    logic reply_ok;
    logic mode_ok;
    logic has_rev;

    assign reply_ok = !ack_n_s_i && err_n_s_i && pe_s_i && slct_s_i;
    assign mode_ok  = slct_s_i || (req_q == NIBBLE_CODE);
    assign has_rev  = !pe_s_i && !err_n_s_i;

    // next-state and outcome selection
    always_comb begin
        state_n   = state_q;
        cnt_clr_o = 1'b0;
        res_we    = 1'b0;
        res_n     = RES_NONCOMPLIANT;
        rev_n     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_n = ST_SETUP;
            end
            ST_SETUP: begin
                state_n   = ST_REQ;
                cnt_clr_o = 1'b1;
            end
            ST_REQ: begin
                if (reply_ok) begin
                    state_n   = ST_STROBE;
                    cnt_clr_o = 1'b1;
                end else if (cnt_i == TMO_LAST) begin
                    state_n = ST_FINISH;
                    res_we  = 1'b1;
                    res_n   = RES_NONCOMPLIANT;
                end
            end
            ST_STROBE: begin
                if (cnt_i == STB_LAST) begin
                    state_n   = ST_RELEASE;
                    cnt_clr_o = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (ack_n_s_i) begin
                    state_n = ST_FINISH;
                    res_we  = 1'b1;
                    res_n   = mode_ok ? RES_ACCEPT : RES_REJECT;
                    rev_n   = has_rev;
                end else if (cnt_i == TMO_LAST) begin
                    state_n = ST_FINISH;
                    res_we  = 1'b1;
                    res_n   = RES_FAIL;
                end
            end
            ST_FINISH: begin
                state_n = ST_IDLE;
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    // state register and latched values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            req_q    <= '0;
            result_q <= RES_NONCOMPLIANT;
            rev_q    <= 1'b0;
        end else begin
            state_q <= state_n;
            if (state_q == ST_IDLE && start_i) req_q <= req_i;
            if (res_we) begin
                result_q <= res_n;
                rev_q    <= rev_n;
            end
        end
    end

    // port line levels per state
    always_comb begin
        data_o      = req_q;
        sel_in_n_o  = 1'b0;
        auto_fd_n_o = 1'b1;
        strobe_n_o  = 1'b1;
        busy_o      = 1'b1;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                data_o = '0;
                busy_o = 1'b0;
            end
            ST_SETUP: begin
            end
            ST_REQ: begin
                sel_in_n_o  = 1'b1;
                auto_fd_n_o = 1'b0;
            end
            ST_STROBE: begin
                sel_in_n_o  = 1'b1;
                auto_fd_n_o = 1'b0;
                strobe_n_o  = 1'b0;
            end
            ST_RELEASE: begin
                sel_in_n_o = 1'b1;
            end
            ST_FINISH: begin
                done_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    assign result_o    = result_q;
    assign rev_avail_o = rev_q;

    // R5 R11
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(data_o));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o) |-> ($stable(result_o) && $stable(rev_avail_o)));

    // R8
    rev_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rev_avail_o |-> (result_o == RES_ACCEPT || result_o == RES_REJECT));

    // R4
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ || state_q == ST_RELEASE) |-> (cnt_i <= TMO_LAST));

endmodule

// File: rtl/nego_seq.sv
module nego_seq #(
    parameter int         TIMEOUT_CLKS = 2000,
    parameter int         STB_CLKS     = 4,
    parameter logic [7:0] NIBBLE_CODE  = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] req_byte_i,
    input  logic       ack_n_i,
    input  logic       err_n_i,
    input  logic       pe_i,
    input  logic       slct_i,
    output logic [7:0] data_o,
    output logic       sel_in_n_o,
    output logic       auto_fd_n_o,
    output logic       strobe_n_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] result_o,
    output logic       rev_avail_o
);

    localparam int STB_EFF  = (STB_CLKS < 1) ? 1 : STB_CLKS;
    localparam int MAX_WAIT = (TIMEOUT_CLKS > STB_EFF) ? TIMEOUT_CLKS : STB_EFF;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    logic [3:0]       raw_in;
    logic [3:0]       syn_in;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt;

    assign raw_in = {ack_n_i, err_n_i, pe_i, slct_i};

    nego_sync #(
        .WIDTH   (4),
        .RST_VAL (4'b1100)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    nego_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .cnt_o (cnt)
    );

    nego_fsm #(
        .TIMEOUT_CLKS (TIMEOUT_CLKS),
        .STB_CLKS     (STB_EFF),
        .CNT_W        (CNT_W),
        .NIBBLE_CODE  (NIBBLE_CODE)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .req_i       (req_byte_i),
        .ack_n_s_i   (syn_in[3]),
        .err_n_s_i   (syn_in[2]),
        .pe_s_i      (syn_in[1]),
        .slct_s_i    (syn_in[0]),
        .cnt_i       (cnt),
        .cnt_clr_o   (cnt_clr),
        .data_o      (data_o),
        .sel_in_n_o  (sel_in_n_o),
        .auto_fd_n_o (auto_fd_n_o),
        .strobe_n_o  (strobe_n_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .result_o    (result_o),
        .rev_avail_o (rev_avail_o)
    );

endmodule

// File: tb/nego_seq_tb.sv
module nego_seq_tb_top;

    localparam int T   = 40;
    localparam int STB = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] req_byte = 8'h00;
    logic       ack_n = 1'b1;
    logic       err_n = 1'b1;
    logic       pe = 1'b0;
    logic       slct = 1'b0;
    logic [7:0] data_o;
    logic       sel_in_n_o, auto_fd_n_o, strobe_n_o, busy_o, done_o, rev_avail_o;
    logic [1:0] result_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    nego_seq #(
        .TIMEOUT_CLKS (T),
        .STB_CLKS     (STB),
        .NIBBLE_CODE  (8'h00)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .req_byte_i  (req_byte),
        .ack_n_i     (ack_n),
        .err_n_i     (err_n),
        .pe_i        (pe),
        .slct_i      (slct),
        .data_o      (data_o),
        .sel_in_n_o  (sel_in_n_o),
        .auto_fd_n_o (auto_fd_n_o),
        .strobe_n_o  (strobe_n_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .result_o    (result_o),
        .rev_avail_o (rev_avail_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        check(data_o == 8'h00 && sel_in_n_o == 1'b0 && auto_fd_n_o == 1'b1 &&
              strobe_n_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0, tag,
              {data_o, sel_in_n_o, auto_fd_n_o, strobe_n_o, busy_o, done_o},
              {8'h00, 5'b01100});
    endtask

    // mode: 0 normal reply, 1 silent device, 2 malformed first reply, 3 Ack# never rises
    task automatic run_case(input logic [7:0] ext, input int mode, input int dly,
                            input logic r_err_n, input logic r_pe, input logic r_slct,
                            input logic f_slct, input logic f_pe, input logic f_err_n,
                            input bit midstart);
        int guard;
        int cnt;
        logic [1:0] exp_res;
        logic exp_rev;
        bit noncomp;
        @(negedge clk);
        req_byte = ext;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        req_byte = ~ext;
        // R2: SETUP cycle, data placed before control lines move
        check(data_o == ext && sel_in_n_o == 1'b0 && auto_fd_n_o == 1'b1 && busy_o,
              "R2 setup", {data_o, sel_in_n_o, auto_fd_n_o}, {ext, 2'b01});
        @(negedge clk);
        check(sel_in_n_o == 1'b1 && auto_fd_n_o == 1'b0 && data_o == ext,
              "R2 request", {data_o, sel_in_n_o, auto_fd_n_o}, {ext, 2'b10});
        noncomp = (mode == 1) || (mode == 2) || (dly > T - 3);
        if (mode == 1) begin
            cnt = 0;
            while (sel_in_n_o && cnt < T + 10) begin
                cnt++;
                @(negedge clk);
            end
            check(cnt == T, "R4 request window", cnt, T);
        end else begin
            repeat (dly) @(negedge clk);
            ack_n = 1'b0;
            err_n = r_err_n;
            pe    = r_pe;
            slct  = r_slct;
        end
        if (midstart) begin
            start = 1'b1;
            req_byte = ~ext;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (strobe_n_o && !done_o && guard < T + 20) begin
            guard++;
            @(negedge clk);
        end
        if (!strobe_n_o) begin
            check(!noncomp, "R4 reply deadline", 1, 0);
            cnt = 0;
            while (!strobe_n_o && cnt < STB + 10) begin
                check(data_o == ext && sel_in_n_o && !auto_fd_n_o, "R5 strobe levels",
                      {data_o, sel_in_n_o, auto_fd_n_o}, {ext, 2'b10});
                cnt++;
                @(negedge clk);
            end
            check(cnt == STB, "R5 strobe width", cnt, STB);
            check(strobe_n_o && auto_fd_n_o && sel_in_n_o && !done_o, "R6 release",
                  {strobe_n_o, auto_fd_n_o, sel_in_n_o, done_o}, 4'b1110);
            slct  = f_slct;
            pe    = f_pe;
            err_n = f_err_n;
            @(negedge clk);
            if (mode != 3) ack_n = 1'b1;
            guard = 0;
            while (!done_o && guard < T + 20) begin
                guard++;
                @(negedge clk);
            end
        end
        check(done_o == 1'b1, "R10 done seen", done_o, 1);
        if (noncomp) begin
            exp_res = 2'b00;
            exp_rev = 1'b0;
        end else if (mode == 3) begin
            exp_res = 2'b11;
            exp_rev = 1'b0;
        end else begin
            exp_res = (f_slct || ext == 8'h00) ? 2'b01 : 2'b10;
            exp_rev = !f_pe && !f_err_n;
        end
        if (noncomp)
            check(result_o == exp_res, "R3 non-compliant", result_o, exp_res);
        else if (mode == 3)
            check(result_o == exp_res, "R9 failed", result_o, exp_res);
        else
            check(result_o == exp_res, "R7 decode", result_o, exp_res);
        check(rev_avail_o == exp_rev, "R8 reverse data", rev_avail_o, exp_rev);
        @(negedge clk);
        check(!done_o && result_o == exp_res && rev_avail_o == exp_rev, "R10 pulse and hold",
              {done_o, result_o, rev_avail_o}, {1'b0, exp_res, exp_rev});
        check_idle("R1 return to idle");
        ack_n = 1'b1;
        err_n = 1'b1;
        pe    = 1'b0;
        slct  = 1'b0;
        repeat (4) @(negedge clk);
        if (midstart) begin
            check(busy_o == 1'b0 && result_o == exp_res, "R11 start ignored",
                  {busy_o, result_o}, {1'b0, exp_res});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] bytes [6];
        bytes = '{8'h00, 8'h01, 8'h04, 8'h10, 8'h14, 8'h30};
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        check(result_o == 2'b00 && rev_avail_o == 1'b0, "R1 reset outcome",
              {result_o, rev_avail_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R1 after reset");

        // decode sweep: bytes x Select x {PaperEnd, Error#}
        for (int e = 0; e < 6; e++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 4; p++) begin
                    run_case(bytes[e], 0, (e * 3 + p + s) % 8, 1'b1, 1'b1, 1'b1,
                             s[0], p[1], p[0], 1'b0);
                end
            end
        end

        // R4 boundary on the reply deadline
        run_case(8'h04, 0, T - 3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        run_case(8'h04, 0, T - 2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        // R3 silent device and malformed replies
        run_case(8'h10, 1, 0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        run_case(8'h10, 2, 0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        run_case(8'h10, 2, 0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        run_case(8'h10, 2, 0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        // R9 Ack# never rises, with reverse-data levels present
        run_case(8'h01, 3, 2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        // R11 start pulse mid-sequence
        run_case(8'h14, 0, 4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        run_case(8'h00, 0, 6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule